// File: doc/BRIEF.md
# Flash Program/Erase Mode Guard

This block holds the entry register that moves two flash regions between read mode and program/erase mode. Software writes a 16-bit word to it. The upper byte must be the entry key and the lower byte picks a region. Only one region can be open for program/erase at a time. An external write-protect pin can block entry. Together with a ready flag, that pin also forces both regions back to read mode.

Every issued command carries an address. The block compares that address against the program/erase window of each region that is currently enabled. A command outside every enabled window sets a sticky lock flag. The lock stays set until a clear input is pulsed.

On the read side, the block reports which regions are in read mode and whether the whole array is in high-speed read mode. It also reports whether a given read address falls in the read window of a region that is currently in read mode.

Top module: `pe_mode_guard`

## Requirements
- R1: After a synchronous reset, both enable bits are 0 and the lock flag is 0.
- R2: A write of 16'hAA01 sets enable bit 0 and a write of 16'hAA02 sets enable bit 1, one cycle after the write. Selecting one region clears the other region's bit.
- R3: A write of 16'hAA00 clears both enable bits. A write whose upper byte is not 8'hAA is ignored. A keyed write with any other lower byte is also ignored.
- R4: While the protect pin is low, a write of 16'hAA01 or 16'hAA02 is ignored and the enable bits keep their value.
- R5: When the ready flag is 1 and the protect pin is low, both enable bits are 0 on the next cycle. This takes priority over any write in the same cycle.
- R6: A command is legal only in these cases:
  - its address lies in 32'hFD80_0000..32'hFD8F_FFFF and enable bit 0 is 1;
  - its address lies in 32'hFD90_0000..32'hFD97_FFFF and enable bit 1 is 1.
  An illegal command sets the lock flag on the next cycle.
- R7: The lock flag is sticky, and further commands do not change it. A lock-clear pulse clears it on the next cycle and takes priority over a command in the same cycle.
- R8: Read-mode bit i is the inverse of enable bit i. The whole-array read indication is 1 only when both enable bits are 0.
- R9: The read-hit output is 1 in two cases:
  - the read address is in 32'h0000_0000..32'h000F_FFFF and enable bit 0 is 0;
  - the read address is in 32'h0010_0000..32'h0017_FFFF and enable bit 1 is 0.
- R10: At most one enable bit is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry register write strobe |
| wr_data | input | 16 | Write word: key in [15:8], region select in [7:0] |
| pe_allow_pin | input | 1 | Protect pin; low blocks entry |
| fl_ready | input | 1 | Flash ready flag |
| cmd_valid | input | 1 | Command-issue strobe |
| cmd_addr | input | 32 | Command address |
| lock_clr | input | 1 | Lock-clear pulse |
| rd_addr | input | 32 | Read address to classify |
| pe_en | output | 2 | Per-region program/erase enable |
| rgn_read | output | 2 | Per-region read-mode indication |
| all_read | output | 1 | Whole array in high-speed read mode |
| rd_ok | output | 1 | Read address in a region that is in read mode |
| cmd_lock | output | 1 | Sticky command-locked flag |

## Verification
The checker covers the following properties on every cycle:
- the at-most-one-enable invariant;
- that no enable bit rises while the protect pin was low;
- the forced clear under ready with the pin low;
- that lock only rises after a command strobe;
- that a lock clear takes effect;
- that an unkeyed write leaves the enables unchanged;
- the reset state.

Only the bench scenarios can show the window boundaries, such as the last byte of each window and the first address past it. The same applies to the choice of which region a key selects, to a legal command leaving the lock untouched, and to the read-hit classification across both read windows.

// File: rtl/pe_guard_pkg.sv
package pe_guard_pkg;
    localparam int ADDR_W  = 32;
    localparam int NUM_RGN = 2;
    localparam logic [7:0] ENTRY_KEY = 8'hAA;
    localparam logic [7:0] SEL_NONE  = 8'h00;

    typedef logic [NUM_RGN-1:0] rgn_vec_t;

    typedef struct packed {
        logic [7:0] key;
        logic [7:0] sel;
    } entry_wr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } win_t;

    // index = region number
    localparam win_t PE_WIN [NUM_RGN] = '{
        '{lo: 32'hFD80_0000, hi: 32'hFD8F_FFFF},
        '{lo: 32'hFD90_0000, hi: 32'hFD97_FFFF}
    };
    localparam win_t RD_WIN [NUM_RGN] = '{
        '{lo: 32'h0000_0000, hi: 32'h000F_FFFF},
        '{lo: 32'h0010_0000, hi: 32'h0017_FFFF}
    };

    function automatic logic in_win(input logic [ADDR_W-1:0] a, input win_t w);
        return (a >= w.lo) && (a <= w.hi);
    endfunction

    // region i is selected by lower-byte code i+1
    function automatic logic [7:0] sel_code(input int idx);
        return 8'(idx + 1);
    endfunction
endpackage

// File: rtl/pe_entry_reg.sv
module pe_entry_reg
    import pe_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic [15:0] wr_data,
    input  logic     allow_pin,
    input  logic     ready,
    output rgn_vec_t en
);
    entry_wr_t wr;
    rgn_vec_t  en_q, en_nxt, sel_hit;

    assign wr = entry_wr_t'(wr_data);

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_sel
        assign sel_hit[g] = (wr.sel == sel_code(g));
    end

    always_comb begin
        en_nxt = en_q;
        if (wr_en && (wr.key == ENTRY_KEY)) begin
            if (wr.sel == SEL_NONE)
                en_nxt = '0;
            else if (allow_pin && (|sel_hit))
                en_nxt = sel_hit;
        end
        if (ready && !allow_pin)
            en_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_nxt;
    end

    assign en = en_q;
endmodule

// File: rtl/pe_cmd_guard.sv
module pe_cmd_guard
    import pe_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rgn_vec_t          en,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              lock_clr,
    output logic              lock
);
    rgn_vec_t win_ok;
    logic     legal, lock_q;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_win
        assign win_ok[g] = en[g] && in_win(cmd_addr, PE_WIN[g]);
    end
    assign legal = |win_ok;

    always_ff @(posedge clk) begin
        if (rst)                          lock_q <= 1'b0;
        else if (lock_clr)                lock_q <= 1'b0;
        else if (!lock_q && cmd_valid && !legal) lock_q <= 1'b1;
    end

    assign lock = lock_q;
endmodule

// File: rtl/pe_read_map.sv
module pe_read_map
    import pe_guard_pkg::*;
(
    input  rgn_vec_t          en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rgn_vec_t          rgn_read,
    output logic              all_read,
    output logic              rd_ok
);
    rgn_vec_t hit;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rd
        assign rgn_read[g] = !en[g];
        assign hit[g]      = rgn_read[g] && in_win(rd_addr, RD_WIN[g]);
    end

    assign all_read = &rgn_read;
    assign rd_ok    = |hit;
endmodule

// File: rtl/pe_mode_guard.sv
module pe_mode_guard
    import pe_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        pe_allow_pin,
    input  logic        fl_ready,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_addr,
    input  logic        lock_clr,
    input  logic [31:0] rd_addr,
    output logic [1:0]  pe_en,
    output logic [1:0]  rgn_read,
    output logic        all_read,
    output logic        rd_ok,
    output logic        cmd_lock
);
    rgn_vec_t en;

    pe_entry_reg u_entry (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .allow_pin(pe_allow_pin), .ready(fl_ready), .en(en)
    );

    pe_cmd_guard u_cmd (
        .clk(clk), .rst(rst), .en(en), .cmd_valid(cmd_valid),
        .cmd_addr(cmd_addr), .lock_clr(lock_clr), .lock(cmd_lock)
    );

    pe_read_map u_rd (
        .en(en), .rd_addr(rd_addr), .rgn_read(rgn_read),
        .all_read(all_read), .rd_ok(rd_ok)
    );

    assign pe_en = en;
endmodule

// File: rtl/pe_mode_guard_chk.sv
module pe_mode_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        pe_allow_pin,
    input logic        fl_ready,
    input logic        cmd_valid,
    input logic        lock_clr,
    input logic [1:0]  pe_en,
    input logic        cmd_lock
);
    // R10
    one_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pe_en));

    // R4
    no_entry_when_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (pe_en != 2'b00 && $past(pe_en) == 2'b00) |-> $past(pe_allow_pin));

    // R5
    forced_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_ready && !pe_allow_pin) |=> (pe_en == 2'b00));

    // R6
    lock_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_lock) |-> $past(cmd_valid));

    // R7
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        lock_clr |=> !cmd_lock);

    // R3
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[15:8] != 8'hAA && !(fl_ready && !pe_allow_pin))
        |=> $stable(pe_en));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pe_en == 2'b00 && !cmd_lock));
endmodule

bind pe_mode_guard pe_mode_guard_chk u_chk (.*);

// File: tb/sim_pe_mode_guard.sv
module sim_pe_mode_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        pe_allow_pin = 1'b1;
    logic        fl_ready = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic        lock_clr = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [1:0]  pe_en, rgn_read;
    logic        all_read, rd_ok, cmd_lock;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [1:0] en;
        logic       lock;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [1:0] m_en = 2'b00;
    logic       m_lock = 1'b0;

    always #2.5 clk = ~clk;

    pe_mode_guard u0 (.*);

    function automatic logic legal(input logic [31:0] a, input logic [1:0] e);
        return (e[0] && a >= 32'hFD80_0000 && a <= 32'hFD8F_FFFF) ||
               (e[1] && a >= 32'hFD90_0000 && a <= 32'hFD97_FFFF);
    endfunction

    // driver: one cycle of stimulus, then push the expected state
    task automatic cyc(input logic w, input logic [15:0] d, input logic pin,
                       input logic rdy, input logic cv, input logic [31:0] ca,
                       input logic clr, input string tag);
        logic [1:0] n_en;
        @(negedge clk);
        wr_en = w; wr_data = d; pe_allow_pin = pin; fl_ready = rdy;
        cmd_valid = cv; cmd_addr = ca; lock_clr = clr;
        n_en = m_en;
        if (w && d[15:8] == 8'hAA) begin
            if (d[7:0] == 8'h00) n_en = 2'b00;
            else if (pin && d[7:0] == 8'h01) n_en = 2'b01;
            else if (pin && d[7:0] == 8'h02) n_en = 2'b10;
        end
        if (rdy && !pin) n_en = 2'b00;
        if (clr) m_lock = 1'b0;
        else if (cv && !legal(ca, m_en)) m_lock = 1'b1;
        m_en = n_en;
        @(posedge clk);
        sb.push_back('{en: m_en, lock: m_lock, tag: tag});
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, tag);
    endtask

    // monitor: compare registered outputs away from the edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (pe_en !== e.en || cmd_lock !== e.lock ||
                    rgn_read !== ~e.en || all_read !== (e.en == 2'b00)) begin
                    errors++;
                    $display("FAIL %s: en=%b lock=%b rr=%b all=%b expected en=%b lock=%b rr=%b all=%b",
                             e.tag, pe_en, cmd_lock, rgn_read, all_read,
                             e.en, e.lock, ~e.en, (e.en == 2'b00));
                end
            end
        end
    end

    task automatic rd_check(input logic [31:0] a, input logic exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        checks++;
        if (rd_ok !== exp) begin
            errors++;
            $display("FAIL %s: rd_ok=%b expected %b at %h", tag, rd_ok, exp, a);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: expected completion, got timeout");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        sb.push_back('{en: 2'b00, lock: 1'b0, tag: "R1 reset"});
        @(negedge clk);
        rst = 1'b0;
        // R2 entry into each region
        cyc(1, 16'hAA01, 1, 0, 0, 0, 0, "R2 set region0");
        cyc(1, 16'hAA02, 1, 0, 0, 0, 0, "R2 region1 clears region0 R10");
        // R3 ignored writes, then clear
        cyc(1, 16'h5501, 1, 0, 0, 0, 0, "R3 bad key");
        cyc(1, 16'hAA07, 1, 0, 0, 0, 0, "R3 bad select");
        cyc(1, 16'hAA00, 1, 0, 0, 0, 0, "R3 clear");
        // R4 blocked entry
        cyc(1, 16'hAA01, 0, 0, 0, 0, 0, "R4 blocked region0");
        cyc(1, 16'hAA01, 1, 0, 0, 0, 0, "R2 set region0 again");
        cyc(1, 16'hAA02, 0, 0, 0, 0, 0, "R4 blocked region1");
        // R9 read hits with region0 in program/erase mode
        rd_check(32'h000F_FFFF, 1'b0, "R9 region0 busy");
        rd_check(32'h0010_0000, 1'b1, "R9 region1 read low edge");
        rd_check(32'h0017_FFFF, 1'b1, "R9 region1 read high edge");
        rd_check(32'h0018_0000, 1'b0, "R9 outside");
        // R6 legal commands
        cyc(0, 0, 1, 0, 1, 32'hFD80_0000, 0, "R6 legal low edge");
        cyc(0, 0, 1, 0, 1, 32'hFD8F_FFFF, 0, "R6 legal high edge");
        cyc(0, 0, 1, 0, 1, 32'hFD90_0000, 0, "R6 wrong region locks");
        // R7 sticky lock
        cyc(0, 0, 1, 0, 1, 32'hFD80_0010, 0, "R7 locked ignores cmd");
        idle("R7 stays locked");
        cyc(0, 0, 1, 0, 1, 32'hFD90_0000, 1, "R7 clear wins over cmd");
        // R6 region1 window
        cyc(1, 16'hAA02, 1, 0, 0, 0, 0, "R2 set region1");
        cyc(0, 0, 1, 0, 1, 32'hFD97_FFFF, 0, "R6 region1 high edge");
        cyc(0, 0, 1, 0, 1, 32'hFD98_0000, 0, "R6 past region1 locks");
        cyc(0, 0, 1, 0, 0, 0, 1, "R7 clear");
        // R5 forced exit
        cyc(0, 0, 0, 0, 0, 0, 0, "R5 pin low without ready keeps");
        cyc(1, 16'hAA02, 0, 1, 0, 0, 0, "R5 forced clear");
        rd_check(32'h0000_0000, 1'b1, "R9 region0 read");
        rd_check(32'h0017_0000, 1'b1, "R9 region1 read both idle");
        // R6 no region enabled
        cyc(0, 0, 1, 0, 1, 32'hFD80_0000, 0, "R6 none enabled locks");
        cyc(0, 0, 1, 0, 0, 0, 1, "R7 clear again");
        idle("R8 idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule